// File: doc/BRIEF.md
# Codec Command and Status Slot Engine

This block moves codec register accesses across the command and status slots of a serial audio link. The host places a 16-bit write value in the data slot register and a register index in the command slot register. Bit 19 of the command word marks the access as a read. A write to the command slot register commits the access. On the next frame-start strobe whose transmit enables allow it, the engine places the pending words in the outgoing frame, along with slot-valid tags and the codec number chosen by the host. A third slot register for the auxiliary slot is sent on its own.

Each transmit slot has a busy flag. The flag rises when the host writes the slot register and falls at the frame-start strobe that takes the word. On the return path, the engine accepts command and status words from a frame only when the frame comes from the codec addressed by the last committed request. Each accepted word sets a valid flag. Reading a receive register through the read port empties it, and a new command write discards any stale responses. The bit serializer and the codec lie outside this block.

Top module: `cmd_slot_engine`

## Requirements
- R1: After reset, all busy flags, all receive-valid flags, the frame tags, the frame slot words and the frame codec field are zero.
- R2: A host write with `wr_sel` 0 (command), 1 (data) or 2 (auxiliary) sets `stat_busy` bit 0, 1 or 2 respectively on the next clock.
- R3: At a frame-start strobe with the command word pending and `ctl_tx_en[0]` set, the next cycle shows the word on `tx_slot1` with `tx_tag[0]` set, and `stat_busy[0]` clear.
- R4: The data word goes out only in the same frame as a committed command word. A pending data word with no pending command stays busy, with `tx_tag[1]` clear and `tx_slot2` zero in that frame.
- R5: While a slot's bit in `ctl_tx_en` (bit 0 command, 1 data, 2 auxiliary) is clear, its word is not sent and its busy flag stays set. The word is sent at the first frame-start after the bit is set.
- R6: The auxiliary word on `tx_slot12` (tag bit 2) is sent whenever it is pending and enabled, independent of the command slot.
- R7: `tx_codec` takes `ctl_codec` at each frame-start. Received words are accepted only when `rx_codec` equals the codec value of the last frame that carried a command word.
- R8: An accepted receive strobe with `rx_tag[0]` (command) or `rx_tag[1]` (data) set stores that word and sets the matching `stat_rxv` bit. `rd_data` shows the command receive word when `rd_sel`=0 and the data receive word when `rd_sel`=1. A read with `rd_en` clears the selected valid bit on the next clock.
- R9: A host write to the command slot register clears both receive-valid flags on the next clock.
- R10: Word layout: command word = {read flag at bit 19, register index at bits 18:12, zeros at 11:0}; data word = {16-bit value at bits 19:4, zeros at 3:0}. The engine carries these words unchanged, so a read of index 0x26 goes out as 0xA6000 and write data 0xBEEF goes out as 0xBEEF0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for a transmit slot register |
| wr_sel | input | 2 | Target register: 0 command, 1 data, 2 auxiliary |
| wr_data | input | 20 | Slot word to be sent |
| rd_en | input | 1 | Host read strobe; empties the selected receive register |
| rd_sel | input | 1 | Receive register: 0 command, 1 data |
| rd_data | output | 20 | Selected receive word |
| ctl_tx_en | input | 3 | Per-slot transmit enables (command, data, auxiliary) |
| ctl_codec | input | 2 | Codec addressed by outgoing frames |
| frame_start | input | 1 | One-cycle strobe that starts an outgoing frame |
| tx_tag | output | 3 | Slot-valid tags of the current frame |
| tx_slot1 | output | 20 | Command word of the current frame |
| tx_slot2 | output | 20 | Data word of the current frame |
| tx_slot12 | output | 20 | Auxiliary word of the current frame |
| tx_codec | output | 2 | Codec number of the current frame |
| rx_strobe | input | 1 | Received frame slot words are present |
| rx_tag | input | 2 | Valid tags of the received command and data words |
| rx_codec | input | 2 | Codec that sent the received frame |
| rx_slot1 | input | 20 | Received command/status word |
| rx_slot2 | input | 20 | Received data word |
| stat_busy | output | 3 | Per-slot transmit busy flags |
| stat_rxv | output | 2 | Receive-valid flags (command, data) |

## Verification
The assertions take for granted that the host does not write a slot register in the same cycle as a frame-start strobe that takes that slot's word. They also take for granted that a read strobe does not arrive in the same cycle as a receive strobe for the same register. With either overlap, the set-then-clear order of the flags would be ambiguous. The directed stimulus keeps host writes, reads, receive strobes and frame-start strobes in separate cycles and changes all inputs on the falling edge.

// File: rtl/cse_pkg.sv
package cse_pkg;
  localparam int SLOT_W  = 20;
  localparam int N_TX    = 3;
  localparam int N_RX    = 2;
  localparam int CODEC_W = 2;

  typedef enum logic [1:0] {
    SEL_CMD = 2'd0,
    SEL_DAT = 2'd1,
    SEL_AUX = 2'd2
  } tx_sel_e;

  // Which slots go out in a frame: data only rides along with a command.
  function automatic logic [N_TX-1:0] fire_mask(input logic [N_TX-1:0] busy,
                                                input logic [N_TX-1:0] en);
    logic cmd;
    cmd = busy[0] & en[0];
    return {busy[2] & en[2], busy[1] & en[1] & cmd, cmd};
  endfunction

  // A received word is kept only if tagged and from the addressed codec.
  function automatic logic rx_accept(input logic tag,
                                     input logic [CODEC_W-1:0] got,
                                     input logic [CODEC_W-1:0] want);
    return tag && (got == want);
  endfunction
endpackage

// File: rtl/cse_tx_slot.sv
module cse_tx_slot #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         consume,
  output logic         pending,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      word    <= '0;
    end else if (load) begin
      pending <= 1'b1;
      word    <= load_word;
    end else if (consume) begin
      pending <= 1'b0;
    end
  end

  a_r2_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pending);
  a_r3_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
    consume && !load |=> !pending);
  a_r5_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !consume && !load |=> pending && $stable(word));
endmodule

// File: rtl/cse_rx_slot.sv
module cse_rx_slot #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] cap_word,
  input  logic         rd,
  input  logic         flush,
  output logic         valid,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      word  <= '0;
    end else if (capture) begin
      valid <= 1'b1;
      word  <= cap_word;
    end else if (rd || flush) begin
      valid <= 1'b0;
    end
  end

  a_r8_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !capture |=> !valid);
  a_r8_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> valid && (word == $past(cap_word)));
endmodule

// File: rtl/cmd_slot_engine.sv
module cmd_slot_engine
  import cse_pkg::*;
#(
  parameter int W  = SLOT_W,
  parameter int CW = CODEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic          rd_sel,
  output logic [W-1:0]  rd_data,
  input  logic [2:0]    ctl_tx_en,
  input  logic [CW-1:0] ctl_codec,
  input  logic          frame_start,
  output logic [2:0]    tx_tag,
  output logic [W-1:0]  tx_slot1,
  output logic [W-1:0]  tx_slot2,
  output logic [W-1:0]  tx_slot12,
  output logic [CW-1:0] tx_codec,
  input  logic          rx_strobe,
  input  logic [1:0]    rx_tag,
  input  logic [CW-1:0] rx_codec,
  input  logic [W-1:0]  rx_slot1,
  input  logic [W-1:0]  rx_slot2,
  output logic [2:0]    stat_busy,
  output logic [1:0]    stat_rxv
);
  logic [W-1:0]    tx_word  [N_TX];
  logic [W-1:0]    out_word [N_TX];
  logic [W-1:0]    rx_in    [N_RX];
  logic [W-1:0]    rx_word  [N_RX];
  logic [N_TX-1:0] fire;
  logic [CW-1:0]   req_codec;
  logic            cmd_write;

  assign fire      = fire_mask(stat_busy, ctl_tx_en);
  assign cmd_write = wr_en && (wr_sel == SEL_CMD);
  assign rx_in[0]  = rx_slot1;
  assign rx_in[1]  = rx_slot2;

  for (genvar g = 0; g < N_TX; g++) begin : g_tx
    cse_tx_slot #(.W(W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (wr_en && (wr_sel == 2'(g))),
      .load_word (wr_data),
      .consume   (frame_start && fire[g]),
      .pending   (stat_busy[g]),
      .word      (tx_word[g])
    );
  end

  for (genvar g = 0; g < N_RX; g++) begin : g_rx
    cse_rx_slot #(.W(W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (rx_strobe && rx_accept(rx_tag[g], rx_codec, req_codec)),
      .cap_word (rx_in[g]),
      .rd       (rd_en && (rd_sel == 1'(g))),
      .flush    (cmd_write),
      .valid    (stat_rxv[g]),
      .word     (rx_word[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_tag    <= '0;
      tx_codec  <= '0;
      req_codec <= '0;
      for (int i = 0; i < N_TX; i++) out_word[i] <= '0;
    end else if (frame_start) begin
      tx_tag   <= fire;
      tx_codec <= ctl_codec;
      if (fire[0]) req_codec <= ctl_codec;
      for (int i = 0; i < N_TX; i++) out_word[i] <= fire[i] ? tx_word[i] : '0;
    end
  end

  assign tx_slot1  = out_word[0];
  assign tx_slot2  = out_word[1];
  assign tx_slot12 = out_word[2];
  assign rd_data   = rd_sel ? rx_word[1] : rx_word[0];

  a_r4_data_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tag[1] |-> tx_tag[0]);
  a_r4_data_waits: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && stat_busy[1] && !stat_busy[0] && !wr_en |=> stat_busy[1] && !tx_tag[1]);
  a_r9_flush_rx: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_write && !rx_strobe |=> stat_rxv == 2'b00);
  a_r7_codec_follow: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> tx_codec == $past(ctl_codec));
endmodule

// File: tb/cmd_slot_engine_bench.sv
module cmd_slot_engine_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [19:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic        rd_sel = 1'b0;
  logic [19:0] rd_data;
  logic [2:0]  ctl_tx_en = '0;
  logic [1:0]  ctl_codec = '0;
  logic        frame_start = 1'b0;
  logic [2:0]  tx_tag;
  logic [19:0] tx_slot1, tx_slot2, tx_slot12;
  logic [1:0]  tx_codec;
  logic        rx_strobe = 1'b0;
  logic [1:0]  rx_tag = '0;
  logic [1:0]  rx_codec = '0;
  logic [19:0] rx_slot1 = '0, rx_slot2 = '0;
  logic [2:0]  stat_busy;
  logic [1:0]  stat_rxv;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  cmd_slot_engine u_cmd_slot_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .ctl_tx_en(ctl_tx_en),
    .ctl_codec(ctl_codec), .frame_start(frame_start), .tx_tag(tx_tag),
    .tx_slot1(tx_slot1), .tx_slot2(tx_slot2), .tx_slot12(tx_slot12),
    .tx_codec(tx_codec), .rx_strobe(rx_strobe), .rx_tag(rx_tag),
    .rx_codec(rx_codec), .rx_slot1(rx_slot1), .rx_slot2(rx_slot2),
    .stat_busy(stat_busy), .stat_rxv(stat_rxv)
  );

  function automatic logic [19:0] cmd_word(input bit rd, input logic [6:0] idx);
    return (20'(rd) << 19) | (20'(idx) << 12);
  endfunction
  function automatic logic [19:0] dat_word(input logic [15:0] v);
    return 20'(v) * 20'd16;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [19:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic frame;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic respond(input logic [1:0] tag, input logic [1:0] cid,
                         input logic [19:0] s1, input logic [19:0] s2);
    rx_strobe = 1'b1; rx_tag = tag; rx_codec = cid; rx_slot1 = s1; rx_slot2 = s2;
    @(negedge clk);
    rx_strobe = 1'b0; rx_tag = '0;
  endtask

  task automatic t_reset;
    chk("R1 busy", 32'(stat_busy), 0);
    chk("R1 rxv", 32'(stat_rxv), 0);
    chk("R1 tag", 32'(tx_tag), 0);
    chk("R1 slot1", 32'(tx_slot1), 0);
    chk("R1 codec", 32'(tx_codec), 0);
  endtask

  task automatic t_data_waits_for_cmd;
    ctl_tx_en = 3'b011; ctl_codec = 2'd0;
    host_write(2'd1, dat_word(16'hBEEF));
    chk("R2 data busy", 32'(stat_busy), 32'b010);
    frame;
    chk("R4 no data tag", 32'(tx_tag), 0);
    chk("R4 data zero", 32'(tx_slot2), 0);
    chk("R4 data still busy", 32'(stat_busy), 32'b010);
    host_write(2'd0, cmd_word(1'b0, 7'h02));
    chk("R2 cmd busy", 32'(stat_busy), 32'b011);
    frame;
    chk("R3 tags", 32'(tx_tag), 32'b011);
    chk("R10 cmd layout", 32'(tx_slot1), 32'h02000);
    chk("R10 data layout", 32'(tx_slot2), 32'hBEEF0);
    chk("R3 busy cleared", 32'(stat_busy), 0);
  endtask

  task automatic t_disabled;
    ctl_tx_en = 3'b000;
    host_write(2'd2, 20'h5A5A5);
    host_write(2'd0, cmd_word(1'b0, 7'h18));
    chk("R2 aux busy", 32'(stat_busy), 32'b101);
    frame;
    chk("R5 no tags", 32'(tx_tag), 0);
    chk("R5 busy held", 32'(stat_busy), 32'b101);
    ctl_tx_en = 3'b100;
    frame;
    chk("R6 aux alone", 32'(tx_tag), 32'b100);
    chk("R6 aux word", 32'(tx_slot12), 32'h5A5A5);
    chk("R6 cmd kept", 32'(stat_busy), 32'b001);
    ctl_tx_en = 3'b111;
    frame;
    chk("R5 sent once enabled", 32'(tx_tag), 32'b001);
    chk("R5 cmd word", 32'(tx_slot1), 32'h18000);
  endtask

  task automatic t_read_cycle;
    ctl_tx_en = 3'b011; ctl_codec = 2'd1;
    host_write(2'd0, cmd_word(1'b1, 7'h26));
    frame;
    chk("R10 read word", 32'(tx_slot1), 32'hA6000);
    chk("R7 frame codec", 32'(tx_codec), 32'd1);
    respond(2'b11, 2'd1, 20'h26000, 20'h12340);
    chk("R8 both valid", 32'(stat_rxv), 32'b11);
    rd_sel = 1'b0; rd_en = 1'b1;
    #1 chk("R8 cmd rx data", 32'(rd_data), 32'h26000);
    @(negedge clk); rd_en = 1'b0;
    chk("R8 cmd read clears", 32'(stat_rxv), 32'b10);
    rd_sel = 1'b1;
    #1 chk("R8 data rx data", 32'(rd_data), 32'h12340);
    host_write(2'd0, cmd_word(1'b1, 7'h7C));
    chk("R9 stale flushed", 32'(stat_rxv), 0);
    ctl_codec = 2'd2;
    frame;
    chk("R7 codec 2", 32'(tx_codec), 32'd2);
    respond(2'b11, 2'd1, 20'h7C000, 20'h0ABC0);
    chk("R7 wrong codec ignored", 32'(stat_rxv), 0);
    respond(2'b01, 2'd2, 20'h7C000, 20'h0ABC0);
    chk("R7 right codec", 32'(stat_rxv), 32'b01);
    rd_sel = 1'b0;
    #1 chk("R8 second word", 32'(rd_data), 32'h7C000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_data_waits_for_cmd;
    t_disabled;
    t_read_cycle;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule